// File: doc/BRIEF.md
# Two-Wire Command Slave with Threshold and Configuration Registers

This block is a write-only slave on an open-drain two-wire serial bus. It runs on a fast system clock and oversamples the bus clock and data lines. It watches for the bus start and stop conditions. After a start it shifts in a control byte that carries its 7-bit address, and then a command byte. It pulls the data line low in the ninth clock of every byte it accepts.

The command byte decides what follows. Two commands set or clear a conversion-run flag and take no data. A configuration command takes one data byte. Each of the two threshold commands takes two data bytes: the high byte comes first, and the 16-bit register changes only once both bytes have arrived. The register values and the run flag are outputs, so neighbouring logic can read them directly. The data line is driven through an active-high pull-low enable.

Top module: `twi_cmd_slave`

## Requirements
- R1: After reset `sda_oe`, `conv_run`, `cfg_q`, `th_q` and `tl_q` are all zero.
- R2: A control byte whose upper seven bits equal 1001 followed by `addr_pins[2:0]`, with bit 0 (the direction bit) at 0, is acknowledged. Acknowledging means the data line is held low through the ninth clock. Any other control byte gets no acknowledge, and no later byte is acknowledged until the next start.
- R3: Command 0x51 sets `conv_run` and command 0x22 clears it. Both are acknowledged. Any further byte before the stop gets no acknowledge.
- R4: Command 0xAC is followed by one data byte, which is acknowledged and stored in `cfg_q`. A second data byte gets no acknowledge and leaves `cfg_q` unchanged.
- R5: Command 0xA1 loads `th_q` and command 0xA2 loads `tl_q`. Each takes two acknowledged data bytes, with bits arriving most significant first. The first byte becomes bits 15:8 and the second becomes bits 7:0. The register is written only when the second byte is accepted.
- R6: A stop or a repeated start between the two bytes of a threshold write leaves the register at its old value. A start in any state restarts the address phase.
- R7: Any other command value gets no acknowledge, and the slave ignores all further bytes until the next start.
- R8: `sda_oe` changes only while the synchronized bus clock is low, except when a start or stop clears it. The slave never pulls the data line low during data bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_pins | input | 3 | Strapped low bits of the slave address |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| conv_run | output | 1 | Conversion-run flag |
| cfg_q | output | 8 | Configuration register |
| th_q | output | 16 | High threshold register |
| tl_q | output | 16 | Low threshold register |

## Verification
The assertions assume that data-line changes happen only while the bus clock is low, except for deliberate start and stop conditions. They also assume each bus-clock level lasts well beyond the three-cycle synchronizer-plus-edge delay. The bench master holds every bus phase for eight system clocks and moves data only in the middle of the low phase. It releases the data line during each acknowledge slot, so only the slave can pull it low there. Aborted threshold writes are placed strictly between bytes, when the slave has already released the line.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 4;

  localparam logic [BYTE_W-1:0] OP_RUN  = 8'h51;
  localparam logic [BYTE_W-1:0] OP_HALT = 8'h22;
  localparam logic [BYTE_W-1:0] OP_CFG  = 8'hAC;
  localparam logic [BYTE_W-1:0] OP_HI   = 8'hA1;
  localparam logic [BYTE_W-1:0] OP_LO   = 8'hA2;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_CMD, PH_DATA, PH_DONE
  } phase_t;

  typedef enum logic [1:0] {
    DST_CFG, DST_HI, DST_LO
  } dest_t;
endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '1;
    else     pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/twi_edge.sv
module twi_edge (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/twi_cmd_fsm.sv
module twi_cmd_fsm
  import twi_pkg::*;
#(
  parameter int             PIN_W     = 3,
  parameter logic [6:0]     ADDR_BASE = 7'b1001000,
  parameter int             THR_W     = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PIN_W-1:0]  addr_pins,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  output logic              sda_oe,
  output logic              conv_run,
  output logic [BYTE_W-1:0] cfg_q,
  output logic [THR_W-1:0]  th_q,
  output logic [THR_W-1:0]  tl_q
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  phase_t             ph, ph_after;
  dest_t              dest;
  logic [BYTE_W-1:0]  shreg, hold;
  logic [CNT_W-1:0]   bitcnt;
  logic               in_ack, second;
  logic [6:0]         my_addr;

  assign my_addr = ADDR_BASE | {{(7-PIN_W){1'b0}}, addr_pins};

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= PH_IDLE;
      ph_after <= PH_IDLE;
      dest     <= DST_CFG;
      shreg    <= '0;
      hold     <= '0;
      bitcnt   <= '0;
      in_ack   <= 1'b0;
      second   <= 1'b0;
      sda_oe   <= 1'b0;
      conv_run <= 1'b0;
      cfg_q    <= '0;
      th_q     <= '0;
      tl_q     <= '0;
    end else if (start_ev || stop_ev) begin
      ph     <= start_ev ? PH_ADDR : PH_IDLE;
      bitcnt <= '0;
      in_ack <= 1'b0;
      second <= 1'b0;
      sda_oe <= 1'b0;
    end else if (ph != PH_IDLE) begin
      if (scl_rise && !in_ack && bitcnt < LAST_BIT) begin
        shreg  <= {shreg[BYTE_W-2:0], sda_s};
        bitcnt <= bitcnt + 1'b1;
      end
      if (scl_fall) begin
        if (in_ack) begin
          in_ack <= 1'b0;
          sda_oe <= 1'b0;
          bitcnt <= '0;
          ph     <= ph_after;
        end else if (bitcnt == LAST_BIT) begin
          in_ack   <= 1'b1;
          ph_after <= PH_DONE;
          unique case (ph)
            PH_ADDR: begin
              if (shreg[7:1] == my_addr && !shreg[0]) begin
                sda_oe   <= 1'b1;
                ph_after <= PH_CMD;
              end
            end
            PH_CMD: begin
              second <= 1'b0;
              case (shreg)
                OP_RUN:  begin sda_oe <= 1'b1; conv_run <= 1'b1; end
                OP_HALT: begin sda_oe <= 1'b1; conv_run <= 1'b0; end
                OP_CFG:  begin sda_oe <= 1'b1; dest <= DST_CFG; ph_after <= PH_DATA; end
                OP_HI:   begin sda_oe <= 1'b1; dest <= DST_HI;  ph_after <= PH_DATA; end
                OP_LO:   begin sda_oe <= 1'b1; dest <= DST_LO;  ph_after <= PH_DATA; end
                default: ;
              endcase
            end
            PH_DATA: begin
              sda_oe <= 1'b1;
              if (dest == DST_CFG) begin
                cfg_q <= shreg;
              end else if (!second) begin
                hold     <= shreg;
                second   <= 1'b1;
                ph_after <= PH_DATA;
              end else if (dest == DST_HI) begin
                th_q <= {hold, shreg};
              end else begin
                tl_q <= {hold, shreg};
              end
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/twi_cmd_slave.sv
module twi_cmd_slave
  import twi_pkg::*;
#(
  parameter int         PIN_W     = 3,
  parameter logic [6:0] ADDR_BASE = 7'b1001000,
  parameter int         SYNC_N    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PIN_W-1:0]  addr_pins,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic              conv_run,
  output logic [BYTE_W-1:0] cfg_q,
  output logic [2*BYTE_W-1:0] th_q,
  output logic [2*BYTE_W-1:0] tl_q
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw, synced;
  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < LINES; g++) begin : g_sync
    twi_sync #(.STAGES(SYNC_N)) u_sync (
      .clk(clk), .rst(rst), .d(raw[g]), .q(synced[g])
    );
  end

  assign scl_s = synced[1];
  assign sda_s = synced[0];

  twi_edge u_edge (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  twi_cmd_fsm #(.PIN_W(PIN_W), .ADDR_BASE(ADDR_BASE), .THR_W(2*BYTE_W)) u_fsm (
    .clk(clk), .rst(rst), .addr_pins(addr_pins), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev),
    .sda_oe(sda_oe), .conv_run(conv_run),
    .cfg_q(cfg_q), .th_q(th_q), .tl_q(tl_q)
  );
endmodule

// File: rtl/twi_cmd_chk.sv
module twi_cmd_chk (
  input logic        clk,
  input logic        rst,
  input logic        scl_s,
  input logic        scl_fall,
  input logic        start_ev,
  input logic        stop_ev,
  input logic        sda_oe,
  input logic        conv_run,
  input logic [7:0]  cfg_q,
  input logic [15:0] th_q,
  input logic [15:0] tl_q
);
  AST_RUN_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !$stable(conv_run) |-> $past(scl_fall)); // R3

  AST_CFG_WITH_ACK: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_q) |-> sda_oe); // R4

  AST_TH_WITH_ACK: assert property (@(posedge clk) disable iff (rst)
    !$stable(th_q) |-> sda_oe); // R5

  AST_TL_WITH_ACK: assert property (@(posedge clk) disable iff (rst)
    !$stable(tl_q) |-> sda_oe); // R5

  AST_RELEASE_ON_COND: assert property (@(posedge clk) disable iff (rst)
    (start_ev || stop_ev) |=> !sda_oe); // R6

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sda_oe) && !$past(start_ev || stop_ev)) |-> !$past(scl_s)); // R8
endmodule

bind twi_cmd_slave twi_cmd_chk u_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .scl_fall(scl_fall),
  .start_ev(start_ev), .stop_ev(stop_ev), .sda_oe(sda_oe),
  .conv_run(conv_run), .cfg_q(cfg_q), .th_q(th_q), .tl_q(tl_q)
);

// File: tb/sim_twi_cmd_slave.sv
`timescale 1ns/1ps
module sim_twi_cmd_slave;
  localparam int Q = 8;
  localparam logic [7:0] AW = 8'h9A;   // 1001_101_0
  localparam logic [7:0] AR = 8'h9B;

  logic clk = 0, rst = 1;
  logic scl = 1, sda_m = 1;
  logic [2:0] pins = 3'b101;
  logic sda_oe, conv_run;
  logic [7:0] cfg_q;
  logic [15:0] th_q, tl_q;
  wire sda_line = sda_m & ~sda_oe;
  int checks = 0, failures = 0, clash = 0;
  bit timeout = 0;

  always #5 clk = ~clk;

  twi_cmd_slave u0 (
    .clk(clk), .rst(rst), .addr_pins(pins), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .conv_run(conv_run), .cfg_q(cfg_q), .th_q(th_q), .tl_q(tl_q)
  );

  task automatic wq(int n); repeat (n) @(negedge clk); endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1; wq(Q); scl = 1; wq(Q); sda_m = 0; wq(Q); scl = 0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 0; wq(Q); scl = 1; wq(Q); sda_m = 1; wq(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(Q); scl = 1; wq(Q);
      if (sda_line !== sda_m) clash++;
      wq(Q); scl = 0; wq(Q);
    end
    sda_m = 1; wq(Q); scl = 1; wq(Q);
    ack = (sda_line === 1'b0);
    wq(Q); scl = 0; wq(Q);
  endtask

  task automatic t_reset();
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 conv_run", conv_run, 0);
    chk("R1 cfg_q", cfg_q, 0);
    chk("R1 th_q", th_q, 0);
    chk("R1 tl_q", tl_q, 0);
  endtask

  task automatic t_run();
    bit a;
    bus_start(); send_byte(AW, a); chk("R2 addr ack", a, 1);
    send_byte(8'h51, a); chk("R3 run cmd ack", a, 1);
    send_byte(8'h00, a); chk("R3 extra byte nack", a, 0);
    bus_stop(); chk("R3 run set", conv_run, 1);
    bus_start(); send_byte(AW, a); send_byte(8'h22, a);
    chk("R3 halt ack", a, 1); bus_stop(); chk("R3 run clear", conv_run, 0);
  endtask

  task automatic t_cfg();
    bit a;
    bus_start(); send_byte(AW, a); send_byte(8'hAC, a); chk("R4 cmd ack", a, 1);
    send_byte(8'h5C, a); chk("R4 data ack", a, 1);
    send_byte(8'h77, a); chk("R4 second byte nack", a, 0);
    bus_stop(); chk("R4 cfg_q", cfg_q, 8'h5C);
  endtask

  task automatic t_thr();
    bit a;
    bus_start(); send_byte(AW, a); send_byte(8'hA1, a); chk("R5 hi cmd ack", a, 1);
    send_byte(8'h12, a); chk("R5 th not yet written", th_q, 0);
    send_byte(8'h34, a); chk("R5 lsb ack", a, 1); bus_stop();
    chk("R5 th_q", th_q, 16'h1234);
    bus_start(); send_byte(AW, a); send_byte(8'hA2, a);
    send_byte(8'hAB, a); send_byte(8'hCD, a); bus_stop();
    chk("R5 tl_q", tl_q, 16'hABCD);
  endtask

  task automatic t_abort();
    bit a;
    bus_start(); send_byte(AW, a); send_byte(8'hA1, a); send_byte(8'hEE, a);
    bus_stop(); chk("R6 th kept after stop", th_q, 16'h1234);
    bus_start(); send_byte(AW, a); send_byte(8'hA2, a); send_byte(8'h99, a);
    bus_start(); send_byte(AW, a); chk("R6 restart addr ack", a, 1);
    send_byte(8'hAC, a); send_byte(8'h3E, a); bus_stop();
    chk("R6 tl kept after restart", tl_q, 16'hABCD);
    chk("R6 cfg via restart", cfg_q, 8'h3E);
  endtask

  task automatic t_badaddr();
    bit a;
    bus_start(); send_byte(8'h92, a); chk("R2 wrong addr nack", a, 0);
    send_byte(8'hAC, a); chk("R2 cmd ignored", a, 0);
    send_byte(8'h01, a); bus_stop(); chk("R2 cfg unchanged", cfg_q, 8'h3E);
    bus_start(); send_byte(AR, a); chk("R2 read dir nack", a, 0); bus_stop();
  endtask

  task automatic t_badcmd();
    bit a;
    bus_start(); send_byte(AW, a); send_byte(8'h33, a); chk("R7 unknown nack", a, 0);
    send_byte(8'h44, a); chk("R7 data ignored", a, 0); bus_stop();
    chk("R7 cfg unchanged", cfg_q, 8'h3E);
    chk("R8 released", sda_oe, 0);
    chk("R8 no pull on data bits", clash, 0);
  endtask

  initial begin
    wq(5); rst = 0; wq(5);
    fork
      begin
        t_reset(); t_run(); t_cfg(); t_thr(); t_abort(); t_badaddr(); t_badcmd();
      end
      begin repeat (150000) @(posedge clk); timeout = 1; end
    join_any
    disable fork;
    if (timeout) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule